// File: doc/BRIEF.md
# Single-Wire Bus Transmit Guard

This block decides whether the transmit driver of a single-wire, half-duplex bus transceiver may drive the line. It samples the transmit data bit and the line level through two-stage synchronizers. It runs two protection checks on them. The first is a mismatch detector: it fires when the transmit bit and the line disagree for too long. The second is a stuck-dominant timeout: it fires when the transmit bit stays low for too long. Both checks drop the transmit enable. One shared rule restores it: the enable comes back only after the transmit bit and the line have both been high for a set number of cycles.

A status pin reports the enable state to the outside world. It can also be taken over from outside. While the override qualifier is active, the pin level forces the transmit path free or disabled, the pin output is tri-stated, and both checks are suspended. The receive output always follows the synchronized line, whatever the transmit state. All windows are parameters counted in clock cycles.

Top module: `txguard_top`

## Requirements
- R1: With the override qualifier inactive, the status pin output enable is 1 and the status output is 0 while transmission is enabled and 1 while it is disabled.
- R2: With the override qualifier active, the status output enable is 0. An override level of 0 forces tx_en_o to 1, and an override level of 1 forces tx_en_o to 0, combinationally.
- R3: While override is active, neither check changes the internal enable state, so after release tx_en_o returns to the state held before the override.
- R4: While enabled, BC_CYC consecutive synchronized cycles of txd_i differing from bus_i disable transmission. BC_CYC-1 such cycles do not.
- R5: While enabled, a falling edge of the synchronized txd_i starts the low timer. A total of LOW_CYC synchronized low cycles, with no qualifying recovery pulse between them, disables transmission. LOW_CYC-1 low cycles do not.
- R6: A high pulse of at least REC_CYC synchronized cycles on txd_i clears the accumulated low time. A high pulse of REC_CYC-1 cycles leaves it in place.
- R7: After a disable, transmission is enabled again once txd_i and bus_i have both been high for ENA_CYC consecutive synchronized cycles. ENA_CYC-1 cycles are not enough.
- R8: During and straight after reset, transmission is disabled (tx_en_o=0, stat_o=1).
- R9: rx_o equals bus_i delayed by two clock edges in every transmit state. drv_o is 1 exactly when tx_en_o is 1 and the synchronized txd_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Transmit data bit (0 = dominant) |
| bus_i | input | 1 | Sampled line level |
| ovr_active_i | input | 1 | Status pin is being driven from outside |
| ovr_level_i | input | 1 | Level driven on the status pin from outside |
| tx_en_o | output | 1 | Transmit path enable |
| drv_o | output | 1 | Gated dominant drive request to the line driver |
| rx_o | output | 1 | Synchronized receive level |
| stat_o | output | 1 | Status pin output value (1 = disabled) |
| stat_oe_o | output | 1 | Status pin output enable |

## Verification
The mismatch detector and the stuck-low timeout can fire in the same cycle. This happens when the transmit bit has been low alongside the line for part of the low timeout, and the line then rises while the transmit bit stays low. The mismatch then reaches BC_CYC in the same cycle that the low total reaches LOW_CYC. The bench provokes this by splitting the low time (5 matched cycles, then 4 mismatched). It expects exactly one disable that ENA_CYC all-high cycles then clear. A companion pattern that stops one cycle short (5 plus 3) must leave transmission enabled.

// File: rtl/txg_pkg.sv
package txg_pkg;

  function automatic int cnt_w(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  function automatic int unsigned sat_next(input int unsigned cur, input int unsigned top);
    return (cur >= top) ? top : cur + 1;
  endfunction

  function automatic logic reached(input int unsigned cur, input int unsigned limit);
    return (cur + 1) >= limit;
  endfunction

endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else if (STAGES == 1) chain_q <= d_i[g];
        else chain_q <= {chain_q[STAGES-2:0], d_i[g]};
      end
      assign q_o[g] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/txg_timer.sv
module txg_timer
  import txg_pkg::*;
#(
  parameter int LIMIT = 4,
  parameter bit HOLD  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int W = cnt_w(LIMIT);
  localparam int unsigned TOP = LIMIT;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else if (run_i) cnt_d = W'(sat_next(int'(cnt_q), TOP));
    else if (HOLD) cnt_d = cnt_q;
    else cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end

  assign done_o = run_i && !clr_i && reached(int'(cnt_q), TOP);
endmodule

// File: rtl/txg_ctrl.sv
module txg_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic bc_trip_i,
  input  logic low_trip_i,
  input  logic ena_done_i,
  output logic en_o
);
  typedef enum logic {ST_OFF = 1'b0, ST_ON = 1'b1} st_e;
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!hold_i) begin
      case (st_q)
        ST_ON:  if (bc_trip_i || low_trip_i) st_d = ST_OFF;
        ST_OFF: if (ena_done_i) st_d = ST_ON;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else st_q <= st_d;
  end

  assign en_o = (st_q == ST_ON);
endmodule

// File: rtl/txguard_top.sv
module txguard_top #(
  parameter int BC_CYC      = 4,
  parameter int ENA_CYC     = 6,
  parameter int LOW_CYC     = 9,
  parameter int REC_CYC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic bus_i,
  input  logic ovr_active_i,
  input  logic ovr_level_i,
  output logic tx_en_o,
  output logic drv_o,
  output logic rx_o,
  output logic stat_o,
  output logic stat_oe_o
);
  localparam int NSIG = 2;

  logic [NSIG-1:0] sync_q;
  logic txd_s, bus_s, txd_d;
  logic fall_ev, armed_q;
  logic checks_on, en_q;
  logic mism_run, low_run, hi_run, ena_run, low_clr;
  logic bc_trip, low_trip, rec_done, ena_done;

  txg_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({bus_i, txd_i}), .q_o(sync_q)
  );
  assign txd_s = sync_q[0];
  assign bus_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd_d <= 1'b1;
    else txd_d <= txd_s;
  end
  assign fall_ev   = txd_d && !txd_s;
  assign checks_on = !ovr_active_i;

  // bit-compare: consecutive mismatch while enabled
  assign mism_run = checks_on && en_q && (txd_s != bus_s);
  txg_timer #(.LIMIT(BC_CYC), .HOLD(1'b0)) u_bc (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .run_i(mism_run), .done_o(bc_trip)
  );

  // recovery pulse: consecutive high on txd
  assign hi_run = checks_on && txd_s;
  txg_timer #(.LIMIT(REC_CYC), .HOLD(1'b0)) u_rec (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .run_i(hi_run), .done_o(rec_done)
  );

  // constant-low: accumulates low time after a falling edge
  assign low_clr = !checks_on || !en_q || rec_done;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (low_clr) armed_q <= 1'b0;
    else if (fall_ev) armed_q <= 1'b1;
  end
  assign low_run = checks_on && en_q && !txd_s && (armed_q || fall_ev);
  txg_timer #(.LIMIT(LOW_CYC), .HOLD(1'b1)) u_low (
    .clk(clk), .rst_n(rst_n), .clr_i(low_clr), .run_i(low_run), .done_o(low_trip)
  );

  // re-enable: both high while disabled
  assign ena_run = checks_on && !en_q && txd_s && bus_s;
  txg_timer #(.LIMIT(ENA_CYC), .HOLD(1'b0)) u_ena (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .run_i(ena_run), .done_o(ena_done)
  );

  txg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hold_i(ovr_active_i),
    .bc_trip_i(bc_trip), .low_trip_i(low_trip), .ena_done_i(ena_done),
    .en_o(en_q)
  );

  assign tx_en_o   = ovr_active_i ? !ovr_level_i : en_q;
  assign drv_o     = tx_en_o && !txd_s;
  assign rx_o      = bus_s;
  assign stat_o    = !en_q;
  assign stat_oe_o = !ovr_active_i;
endmodule

// File: rtl/txg_chk.sv
module txg_chk (
  input logic clk,
  input logic rst_n,
  input logic ovr_active_i,
  input logic ovr_level_i,
  input logic tx_en_o,
  input logic stat_o,
  input logic stat_oe_o,
  input logic en_q,
  input logic bc_trip,
  input logic low_trip,
  input logic ena_done
);
  assert_stat_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_active_i |-> (stat_oe_o && (stat_o == !tx_en_o)));

  assert_force_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_active_i |-> (!stat_oe_o && (tx_en_o == !ovr_level_i)));

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_active_i |=> $stable(en_q));

  assert_bc_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_trip && en_q && !ovr_active_i) |=> !en_q);

  assert_low_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_trip && en_q && !ovr_active_i) |=> !en_q);

  assert_reenable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ena_done) |=> !en_q);

  always_comb begin
    if (!rst_n) assert_reset_off_R8: assert (!en_q);
  end
endmodule

bind txguard_top txg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovr_active_i(ovr_active_i), .ovr_level_i(ovr_level_i),
  .tx_en_o(tx_en_o), .stat_o(stat_o), .stat_oe_o(stat_oe_o), .en_q(en_q),
  .bc_trip(bc_trip), .low_trip(low_trip), .ena_done(ena_done)
);

// File: tb/tb_txguard_top.sv
module tb_txguard_top;
  localparam int BC = 4, ENA = 6, LOW = 9, REC = 3;

  logic clk = 0, rst_n = 0;
  logic txd = 1, bus = 1, ovr = 0, lvl = 0;
  logic tx_en, drv, rx, stat, stat_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  txguard_top #(.BC_CYC(BC), .ENA_CYC(ENA), .LOW_CYC(LOW), .REC_CYC(REC)) dut (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .bus_i(bus), .ovr_active_i(ovr),
    .ovr_level_i(lvl), .tx_en_o(tx_en), .drv_o(drv), .rx_o(rx), .stat_o(stat),
    .stat_oe_o(stat_oe)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set(logic t, logic b, int n);
    txd = t; bus = b; cyc(n);
  endtask

  // status pin mirrors the enable (R1)
  task automatic check_state(string req, logic exp_en);
    check(req, tx_en, exp_en);
    check({req, "/R1 stat"}, stat, !exp_en);
    check({req, "/R1 oe"}, stat_oe, 1'b1);
  endtask

  task automatic go_enabled();
    set(1, 1, ENA + 4);
  endtask

  task automatic go_disabled();
    set(1, 0, BC + 3);
    set(1, 1, 1);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    cyc(150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    cyc(2);
    check("R8 reset en", tx_en, 0);
    check("R8 reset stat", stat, 1);
    rst_n = 1;
    cyc(1);
    check("R8 after reset", tx_en, 0);
    set(1, 1, ENA - 3);
    check("R8 still off before ena", tx_en, 0);
    go_enabled();
    check_state("R7 first enable", 1);

    // R4 sweep of mismatch duration
    for (int d = 1; d <= BC + 2; d++) begin
      go_enabled();
      set(0, 1, d);
      set(1, 1, 3);
      check_state($sformatf("R4 mismatch d=%0d", d), d < BC);
      go_enabled();
      check_state("R7 after R4", 1);
    end

    // R5 sweep of low duration (bus follows)
    for (int d = 1; d <= LOW + 2; d++) begin
      go_enabled();
      set(0, 0, d);
      set(1, 1, 3);
      check_state($sformatf("R5 low d=%0d", d), d < LOW);
    end

    // R6 recovery pulse width sweep: 5 low, h high, 5 low
    for (int h = 1; h <= REC + 1; h++) begin
      go_enabled();
      set(0, 0, 5);
      set(1, 1, h);
      set(0, 0, 5);
      set(1, 1, 3);
      check_state($sformatf("R6 rec h=%0d", h), h >= REC);
    end

    // R7 re-enable window sweep
    for (int d = 1; d <= ENA + 2; d++) begin
      go_enabled();
      go_disabled();
      check_state("R7 disabled", 0);
      set(1, 0, 4);
      set(1, 1, d);
      set(1, 0, 3);
      check_state($sformatf("R7 ena d=%0d", d), d >= ENA);
      set(1, 1, 1);
    end

    // same-cycle trips: 5 matched low then 4 mismatched (both fire), 5+3 (neither)
    go_enabled();
    set(0, 0, 5); set(0, 1, 4); set(1, 1, 3);
    check_state("R4/R5 coincident trip", 0);
    go_enabled();
    check_state("R7 after coincident", 1);
    set(0, 0, 5); set(0, 1, 3); set(1, 1, 3);
    check_state("R4/R5 one short", 1);

    // R2/R3 override sweep over level and prior state
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < 2; l++) begin
        go_enabled();
        if (p == 0) go_disabled();
        ovr = 1; lvl = l[0];
        cyc(1);
        check($sformatf("R2 force l=%0d", l), tx_en, !l[0]);
        check("R2 oe off", stat_oe, 0);
        set(0, 1, BC + 3);
        set(0, 0, LOW + 2);
        set(1, 1, 1);
        check("R2 still forced", tx_en, !l[0]);
        ovr = 0;
        cyc(1);
        check_state($sformatf("R3 restore p=%0d l=%0d", p, l), p[0]);
      end
    end

    // R9 receive path and drive gating
    go_enabled();
    go_disabled();
    begin
      logic [1:0] hist = 2'b11;
      for (int k = 0; k < 10; k++) begin
        logic nb;
        nb = ((k * 7 + 3) % 5) < 2;
        hist = {hist[0], nb};
        txd = 1; bus = nb;
        cyc(1);
        if (k >= 1) check($sformatf("R9 rx k=%0d", k), rx, hist[1]);
      end
    end
    set(1, 1, 2);
    check("R9 drv disabled", drv, 0);
    go_enabled();
    set(0, 0, 3);
    check("R9 drv enabled low", drv, 1);
    check("R9 rx while tx", rx, 0);
    set(1, 1, 3);
    check("R9 drv enabled high", drv, 0);

    done = 1;
    report();
  end
endmodule